// File: doc/BRIEF.md
# Strip Zero-Suppression Unit

This unit reduces the sample stream of one front-end input to the strips that carry signal. Each strip of a frame arrives as a group of six consecutive signed samples, each tagged with its strip index and sample number. As each sample is captured, the stored pedestal of its strip is subtracted and the result is written into a frame store. At the same time it is added into one running sum per sample number. When the frame's last sample has been taken, a scan pass visits the strips in ascending order. For every sample number it removes the common-mode level, which is the mean of that sample number's pedestal-corrected values over all strips. It then tests the six corrected values against the strip's own threshold.

A strip is kept when any of its six corrected values is strictly greater than its threshold. A kept strip is sent as two output words that carry its index and the six corrected values. Strips that are not kept produce nothing. A single-cycle done flag closes each frame. Pedestal and threshold values are loaded per strip through an address/data configuration port. That port may be written at any time.

Top module: `strip_zs`

## Requirements
- R1: While reset is held, and until the first frame is scanned, `hit_valid` and `frame_done` are 0.
- R2: A captured sample has the pedestal of its strip subtracted, using the value held before that clock edge. A pedestal write (`cfg_sel`=0) in the same cycle as a capture of the same strip takes effect only from the following capture.
- R3: The common-mode level of sample number t is the sum of the pedestal-corrected values of sample t over all 128 strips, arithmetically shifted right by 7. It is subtracted from each of those values to give the corrected value.
- R4: A strip is kept if and only if at least one of its six corrected values is strictly greater than its own signed threshold, written with `cfg_sel`=1.
- R5: A kept strip yields two words on consecutive cycles. The first word has `hit_tail`=0 and holds the strip index in bits 36:30 and corrected samples 0, 1 and 2 in bits 29:20, 19:10 and 9:0. The second word has `hit_tail`=1, bits 36:30 zero, and samples 3, 4 and 5 in the same slots. Each value is saturated to the range -512 to 511.
- R6: Kept strips are emitted in ascending strip order.
- R7: A frame with no kept strip produces no output words.
- R8: `frame_done` is high for exactly one cycle per frame, in the cycle after the last strip is finished. When strip 127 is kept, that cycle is the one holding its second word; otherwise `hit_valid` is 0 in that cycle.
- R9: Input samples, including one marked last, are ignored from the cycle after the last sample of a frame is accepted until `frame_done` has been shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_strip | input | 7 | Strip index of the sample |
| in_samp | input | 3 | Sample number 0..5 |
| in_last | input | 1 | Marks the final sample of a frame |
| in_raw | input | 10 | Signed raw sample |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | 0 selects pedestal, 1 selects threshold |
| cfg_addr | input | 7 | Strip index of the table entry |
| cfg_data | input | 10 | Signed table value |
| hit_valid | output | 1 | Output word present |
| hit_word | output | 37 | Packed hit word |
| hit_tail | output | 1 | Word is the second word of a strip |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
A pedestal write can land in the same cycle as the capture of a sample from that same strip. The bench provokes this by writing a new pedestal for strip 5 exactly while sample 0 of strip 5 is presented. It then checks from the emitted words that sample 0 was corrected with the old pedestal and samples 1 to 5 with the new one. The end-of-frame flag can also coincide with the second word of strip 127. A frame that keeps strip 127 must show both in one cycle, and frames that do not keep it must show the flag alone.

// File: rtl/strip_zs_pkg.sv
package strip_zs_pkg;
  typedef enum logic [1:0] {
    ZS_COLLECT = 2'd0,
    ZS_SCAN    = 2'd1,
    ZS_EMIT    = 2'd2
  } zs_state_t;

  localparam logic CFG_PED = 1'b0;
  localparam logic CFG_THR = 1'b1;
endpackage

// File: rtl/strip_zs_tables.sv
module strip_zs_tables #(
  parameter int NSTRIP = 128,
  parameter int SW     = 10,
  localparam int AW    = $clog2(NSTRIP)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [AW-1:0] ped_addr,
  output logic [SW-1:0] ped_val,
  input  logic [AW-1:0] thr_addr,
  output logic [SW-1:0] thr_val
);
  import strip_zs_pkg::*;

  logic [SW-1:0] ped_mem [NSTRIP];
  logic [SW-1:0] thr_mem [NSTRIP];

  // table storage is not reset: software loads every entry before use
  always_ff @(posedge clk) begin
    if (we && (sel == CFG_PED)) ped_mem[waddr] <= wdata;
    if (we && (sel == CFG_THR)) thr_mem[waddr] <= wdata;
  end

  assign ped_val = ped_mem[ped_addr];
  assign thr_val = thr_mem[thr_addr];
endmodule

// File: rtl/strip_zs_store.sv
module strip_zs_store #(
  parameter int NSTRIP = 128,
  parameter int NSAMP  = 6,
  parameter int DW     = 11,
  localparam int AW    = $clog2(NSTRIP),
  localparam int SAW   = $clog2(NSAMP),
  localparam int ACCW  = DW + AW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_strip,
  input  logic [SAW-1:0]        wr_samp,
  input  logic [DW-1:0]         wr_val,
  input  logic                  clr,
  input  logic [AW-1:0]         rd_strip,
  output logic [NSAMP*DW-1:0]   rd_row,
  output logic [NSAMP*DW-1:0]   cm_row
);
  logic [NSAMP*DW-1:0] row_mem [NSTRIP];
  logic signed [ACCW-1:0] acc_q [NSAMP];
  logic signed [ACCW-1:0] acc_d [NSAMP];
  logic signed [ACCW-1:0] wr_ext;

  assign wr_ext = $signed({{AW{wr_val[DW-1]}}, wr_val});

  always_ff @(posedge clk) begin
    if (wr_en) row_mem[wr_strip][wr_samp*DW +: DW] <= wr_val;
  end

  assign rd_row = row_mem[rd_strip];

  always_comb begin
    for (int t = 0; t < NSAMP; t++) begin
      acc_d[t] = acc_q[t];
      if (clr)
        acc_d[t] = '0;
      else if (wr_en && (int'(wr_samp) == t))
        acc_d[t] = acc_q[t] + wr_ext;
    end
  end

  for (genvar g = 0; g < NSAMP; g++) begin : g_acc
    logic signed [ACCW-1:0] mean;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        acc_q[g] <= '0;
      else if (clr || wr_en)
        acc_q[g] <= acc_d[g];
    end
    assign mean = acc_q[g] >>> AW;
    assign cm_row[g*DW +: DW] = mean[DW-1:0];
  end
endmodule

// File: rtl/strip_zs_scan.sv
module strip_zs_scan #(
  parameter int NSTRIP = 128,
  parameter int NSAMP  = 6,
  parameter int SW     = 10,
  parameter int SPW    = 3,
  localparam int AW    = $clog2(NSTRIP),
  localparam int DW    = SW + 1,
  localparam int CW    = DW + 1,
  localparam int NW    = NSAMP / SPW,
  localparam int WIW   = (NW > 1) ? $clog2(NW) : 1,
  localparam int OW    = AW + SPW * SW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NSAMP*DW-1:0]  rd_row,
  input  logic [NSAMP*DW-1:0]  cm_row,
  input  logic [SW-1:0]        thr,
  output logic [AW-1:0]        rd_strip,
  output logic                 busy,
  output logic                 clr_acc,
  output logic                 hit_valid,
  output logic [OW-1:0]        hit_word,
  output logic                 hit_tail,
  output logic                 frame_done
);
  import strip_zs_pkg::*;

  localparam int SMAX = 2**(SW-1) - 1;
  localparam int SMIN = -(2**(SW-1));

  zs_state_t st_q, st_d;
  logic [AW-1:0]       strip_q, strip_d;
  logic [WIW-1:0]      widx_q, widx_d;
  logic [NSAMP*SW-1:0] satr_q, satr_d;
  logic                hv_q, hv_d, ht_q, ht_d, done_q, done_d;
  logic [OW-1:0]       hw_q, hw_d;
  logic [NSAMP*SW-1:0] sat_now;
  logic [NSAMP-1:0]    over;
  logic                kept, last_strip;

  function automatic logic [OW-1:0] mk_word(input logic [NSAMP*SW-1:0] row,
                                            input int k,
                                            input logic [AW-1:0] idx);
    logic [OW-1:0] w;
    w = '0;
    w[OW-1 -: AW] = idx;
    for (int j = 0; j < SPW; j++)
      w[(SPW-1-j)*SW +: SW] = row[(k*SPW+j)*SW +: SW];
    return w;
  endfunction

  for (genvar g = 0; g < NSAMP; g++) begin : g_corr
    logic signed [CW-1:0] corr;
    logic signed [CW-1:0] thr_e;
    assign corr  = $signed({rd_row[g*DW+DW-1], rd_row[g*DW +: DW]})
                 - $signed({cm_row[g*DW+DW-1], cm_row[g*DW +: DW]});
    assign thr_e = $signed({{(CW-SW){thr[SW-1]}}, thr});
    assign over[g] = corr > thr_e;
    always_comb begin
      if (corr > SMAX)      sat_now[g*SW +: SW] = SW'(SMAX);
      else if (corr < SMIN) sat_now[g*SW +: SW] = SW'(SMIN);
      else                  sat_now[g*SW +: SW] = corr[SW-1:0];
    end
  end

  assign kept       = |over;
  assign last_strip = (int'(strip_q) == NSTRIP - 1);

  always_comb begin
    st_d    = st_q;
    strip_d = strip_q;
    widx_d  = widx_q;
    satr_d  = satr_q;
    hw_d    = hw_q;
    hv_d    = 1'b0;
    ht_d    = 1'b0;
    done_d  = 1'b0;
    clr_acc = 1'b0;
    unique case (st_q)
      ZS_COLLECT: begin
        if (start) begin
          st_d    = ZS_SCAN;
          strip_d = '0;
        end
      end
      ZS_SCAN: begin
        if (kept) begin
          hv_d   = 1'b1;
          hw_d   = mk_word(sat_now, 0, strip_q);
          satr_d = sat_now;
          widx_d = WIW'(1);
          st_d   = ZS_EMIT;
        end else if (last_strip) begin
          done_d  = 1'b1;
          clr_acc = 1'b1;
          st_d    = ZS_COLLECT;
        end else begin
          strip_d = strip_q + 1'b1;
        end
      end
      ZS_EMIT: begin
        hv_d = 1'b1;
        ht_d = 1'b1;
        hw_d = mk_word(satr_q, int'(widx_q), '0);
        if (int'(widx_q) == NW - 1) begin
          if (last_strip) begin
            done_d  = 1'b1;
            clr_acc = 1'b1;
            st_d    = ZS_COLLECT;
          end else begin
            strip_d = strip_q + 1'b1;
            st_d    = ZS_SCAN;
          end
        end else begin
          widx_d = widx_q + 1'b1;
        end
      end
      default: st_d = ZS_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ZS_COLLECT;
      strip_q <= '0;
      widx_q  <= '0;
      hv_q    <= 1'b0;
      ht_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      strip_q <= strip_d;
      widx_q  <= widx_d;
      hv_q    <= hv_d;
      ht_q    <= ht_d;
      done_q  <= done_d;
    end
  end

  // data registers only load alongside a word, no reset needed
  always_ff @(posedge clk) begin
    if (hv_d) hw_q <= hw_d;
    if (st_q == ZS_SCAN && kept) satr_q <= satr_d;
  end

  assign rd_strip   = strip_q;
  assign busy       = (st_q != ZS_COLLECT);
  assign hit_valid  = hv_q;
  assign hit_word   = hw_q;
  assign hit_tail   = ht_q;
  assign frame_done = done_q;
endmodule

// File: rtl/strip_zs.sv
module strip_zs #(
  parameter int NSTRIP = 128,
  parameter int NSAMP  = 6,
  parameter int SW     = 10,
  parameter int SPW    = 3,
  localparam int AW    = $clog2(NSTRIP),
  localparam int SAW   = $clog2(NSAMP),
  localparam int DW    = SW + 1,
  localparam int OW    = AW + SPW * SW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [AW-1:0]  in_strip,
  input  logic [SAW-1:0] in_samp,
  input  logic           in_last,
  input  logic [SW-1:0]  in_raw,
  input  logic           cfg_we,
  input  logic           cfg_sel,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [SW-1:0]  cfg_data,
  output logic           hit_valid,
  output logic [OW-1:0]  hit_word,
  output logic           hit_tail,
  output logic           frame_done
);
  logic rst_s1, rst_s2;
  logic [SW-1:0] ped_val, thr_val;
  logic [AW-1:0] rd_strip;
  logic [NSAMP*DW-1:0] rd_row, cm_row;
  logic busy, clr_acc, cap_en, start;
  logic [DW-1:0] diff;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign cap_en = in_valid && !busy;
  assign start  = cap_en && in_last;
  assign diff   = {in_raw[SW-1], in_raw} - {ped_val[SW-1], ped_val};

  strip_zs_tables #(.NSTRIP(NSTRIP), .SW(SW)) u_tables (
    .clk      (clk),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .waddr    (cfg_addr),
    .wdata    (cfg_data),
    .ped_addr (in_strip),
    .ped_val  (ped_val),
    .thr_addr (rd_strip),
    .thr_val  (thr_val)
  );

  strip_zs_store #(.NSTRIP(NSTRIP), .NSAMP(NSAMP), .DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_s2),
    .wr_en    (cap_en),
    .wr_strip (in_strip),
    .wr_samp  (in_samp),
    .wr_val   (diff),
    .clr      (clr_acc),
    .rd_strip (rd_strip),
    .rd_row   (rd_row),
    .cm_row   (cm_row)
  );

  strip_zs_scan #(.NSTRIP(NSTRIP), .NSAMP(NSAMP), .SW(SW), .SPW(SPW)) u_scan (
    .clk        (clk),
    .rst_n      (rst_s2),
    .start      (start),
    .rd_row     (rd_row),
    .cm_row     (cm_row),
    .thr        (thr_val),
    .rd_strip   (rd_strip),
    .busy       (busy),
    .clr_acc    (clr_acc),
    .hit_valid  (hit_valid),
    .hit_word   (hit_word),
    .hit_tail   (hit_tail),
    .frame_done (frame_done)
  );
endmodule

// File: rtl/strip_zs_chk.sv
module strip_zs_chk #(
  parameter int OW = 37
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hit_valid,
  input logic [OW-1:0] hit_word,
  input logic          hit_tail,
  input logic          frame_done
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (!hit_valid && !frame_done)
        else $error("R1 output active during reset");
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_done_then_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !hit_valid);

  p_tail_follows_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_tail) |=> (hit_valid && hit_tail));

  p_tail_has_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_tail) |-> $past(hit_valid && !hit_tail));

  p_done_not_on_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !(hit_valid && !hit_tail));
endmodule

bind strip_zs strip_zs_chk #(.OW(OW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_valid  (hit_valid),
  .hit_word   (hit_word),
  .hit_tail   (hit_tail),
  .frame_done (frame_done)
);

// File: tb/strip_zs_bench.sv
module strip_zs_bench;
  localparam int N  = 128;
  localparam int NS = 6;

  typedef struct packed {
    int ped; int thr; int ha; int aa; int hb; int ab; int cmo; int en;
  } vec_t;

  // pedestal, threshold, hit A strip/amp, hit B strip/amp, cm offset, expected kept strips
  localparam vec_t VECS [0:4] = '{
    '{30,   20,  10,  90,  77,  90,    5, 2},
    '{-40,  20,   3, -90,  50,  12,  -30, 0},
    '{0,    20,   0, 200, 127, 200,    0, 2},
    '{-200, 30,  64, 600,  64,   0,    0, 1},
    '{10,  300,  20, 200,  21,   0,    0, 0}
  };

  logic clk, rst_n;
  logic in_valid, in_last, cfg_we, cfg_sel;
  logic [6:0] in_strip, cfg_addr;
  logic [2:0] in_samp;
  logic [9:0] in_raw, cfg_data;
  logic hit_valid, hit_tail, frame_done;
  logic [36:0] hit_word;

  strip_zs u_strip_zs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_strip(in_strip),
    .in_samp(in_samp), .in_last(in_last), .in_raw(in_raw), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .hit_valid(hit_valid), .hit_word(hit_word), .hit_tail(hit_tail),
    .frame_done(frame_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk, n_fail, cyc;
  int raw [N][NS];
  int pused [N][NS];
  int pedt [N];
  int thrt [N];
  logic [36:0] exp_w [512];
  logic        exp_t [512];
  int n_exp;
  logic last_kept;
  logic [36:0] cap_w [512];
  logic        cap_t [512];
  int n_cap, n_done;
  logic done_hv, done_tail, clr_cap;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (clr_cap) begin
      n_cap = 0; n_done = 0; done_hv = 1'b0; done_tail = 1'b0;
    end else if (rst_n) begin
      if (hit_valid && n_cap < 512) begin
        cap_w[n_cap] = hit_word; cap_t[n_cap] = hit_tail; n_cap = n_cap + 1;
      end
      if (frame_done) begin
        n_done = n_done + 1; done_hv = hit_valid; done_tail = hit_tail;
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cyc = 0;
    wait (cyc == 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
    finish_run();
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input int addr, input int val);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 7'(addr); cfg_data = 10'(val);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic load_tables();
    for (int s = 0; s < N; s++) cfg_write(1'b0, s, pedt[s]);
    for (int s = 0; s < N; s++) cfg_write(1'b1, s, thrt[s]);
  endtask

  task automatic gen_frame(input vec_t v);
    for (int s = 0; s < N; s++)
      for (int t = 0; t < NS; t++) begin
        raw[s][t] = v.ped + v.cmo + ((s*7 + t*3) % 9) - 4;
        if (s == v.ha) raw[s][t] += v.aa * (1 + t % 3) / 3;
        if (s == v.hb) raw[s][t] += v.ab * (1 + t % 3) / 3;
      end
  endtask

  // ws >= 0: write pedestal wv to strip ws together with its sample 0
  task automatic drive_frame(input int ws, input int wv);
    clr_cap = 1'b1;
    @(posedge clk); #1;
    clr_cap = 1'b0;
    for (int s = 0; s < N; s++)
      for (int t = 0; t < NS; t++) begin
        in_valid = 1'b1; in_strip = 7'(s); in_samp = 3'(t);
        in_raw = 10'(raw[s][t]); in_last = (s == N-1) && (t == NS-1);
        pused[s][t] = pedt[s];
        if (s == ws && t == 0) begin
          cfg_we = 1'b1; cfg_sel = 1'b0; cfg_addr = 7'(s); cfg_data = 10'(wv);
          pedt[s] = wv;
        end
        @(posedge clk); #1;
        cfg_we = 1'b0;
      end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  function automatic int sat10(input int x);
    return (x > 511) ? 511 : ((x < -512) ? -512 : x);
  endfunction

  task automatic model();
    int cm [NS];
    int c [NS];
    logic k;
    n_exp = 0; last_kept = 1'b0;
    for (int t = 0; t < NS; t++) begin
      int sum = 0;
      for (int s = 0; s < N; s++) sum += raw[s][t] - pused[s][t];
      cm[t] = sum >>> 7;
    end
    for (int s = 0; s < N; s++) begin
      k = 1'b0;
      for (int t = 0; t < NS; t++) begin
        c[t] = raw[s][t] - pused[s][t] - cm[t];
        if (c[t] > thrt[s]) k = 1'b1;
      end
      if (k) begin
        exp_w[n_exp] = {7'(s), 10'(sat10(c[0])), 10'(sat10(c[1])), 10'(sat10(c[2]))};
        exp_t[n_exp] = 1'b0;
        exp_w[n_exp+1] = {7'd0, 10'(sat10(c[3])), 10'(sat10(c[4])), 10'(sat10(c[5]))};
        exp_t[n_exp+1] = 1'b1;
        n_exp += 2;
        if (s == N-1) last_kept = 1'b1;
      end
    end
  endtask

  task automatic wait_done();
    int w = 0;
    while (n_done == 0 && w < 2000) begin @(posedge clk); w++; end
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic compare(input int exp_strips);
    chk(n_cap == n_exp, "R4/R7 word count", n_cap, n_exp);
    if (exp_strips >= 0) chk(n_cap == 2*exp_strips, "R4 kept strips", n_cap/2, exp_strips);
    for (int i = 0; i < n_exp && i < n_cap; i++) begin
      chk(cap_w[i] == exp_w[i], "R5/R3/R6 word", cap_w[i], exp_w[i]);
      chk(cap_t[i] == exp_t[i], "R5 tail flag", cap_t[i], exp_t[i]);
    end
    chk(n_done == 1, "R8 done pulses", n_done, 1);
    chk(done_hv == last_kept && done_tail == last_kept, "R8 done alignment", done_hv, last_kept);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; clr_cap = 1'b0;
    n_cap = 0; n_done = 0; done_hv = 1'b0; done_tail = 1'b0;
    rst_n = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_strip = '0; in_samp = '0;
    in_raw = '0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_addr = '0; cfg_data = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(hit_valid == 1'b0, "R1 hit_valid in reset", hit_valid, 0);
    chk(frame_done == 1'b0, "R1 frame_done in reset", frame_done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!hit_valid && !frame_done, "R1 idle after reset", hit_valid, 0);

    foreach (VECS[i]) begin
      for (int s = 0; s < N; s++) begin pedt[s] = VECS[i].ped; thrt[s] = VECS[i].thr; end
      load_tables();
      gen_frame(VECS[i]);
      drive_frame(-1, 0);
      model();
      wait_done();
      compare(VECS[i].en);
    end

    // R2: pedestal write coinciding with capture; R4: per-strip threshold
    for (int s = 0; s < N; s++) begin pedt[s] = 30; thrt[s] = 20; end
    thrt[40] = -50;
    load_tables();
    gen_frame('{30, 20, 5, 90, 200, 0, 0, 2});
    drive_frame(5, -100);
    model();
    wait_done();
    compare(2);
    chk(n_cap > 1 && cap_w[0][36:30] == 7'd5, "R2 strip 5 kept", cap_w[0][36:30], 5);

    // R9: stray samples marked last while the scan runs
    for (int s = 0; s < N; s++) begin pedt[s] = 0; thrt[s] = 40; end
    load_tables();
    gen_frame('{0, 40, 60, 120, 200, 0, 0, 1});
    drive_frame(-1, 0);
    for (int i = 0; i < 10; i++) begin
      in_valid = 1'b1; in_last = 1'b1; in_strip = 7'(120 + i % 8);
      in_samp = 3'(i % 6); in_raw = 10'sd400;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
    model();
    wait_done();
    compare(1);
    repeat (1000) @(posedge clk);
    #1;
    chk(n_done == 1, "R9 no extra frame", n_done, 1);
    chk(n_cap == n_exp, "R9 no stray words", n_cap, n_exp);

    finish_run();
  end
endmodule